// File: doc/BRIEF.md
# Fan Speed Selector with Auto-Park

This block chooses one of four fan speed levels with a single button and switches the fan off on its own whenever the downstream device is not asking for airflow. Each button pulse moves the selection to the next faster level. After the fastest level it goes back to the slowest. While the device-active flag is low the block sits in a fifth, parked state in which the fan is disabled. The chosen level is kept in a separate register, so a returning request brings back exactly the speed that was running before.

The button input must be a clean single-cycle pulse, synchronous to the block clock; debouncing happens upstream. Three outputs are available. A binary code always shows the remembered level. A one-hot vector is all zeros while parked. A single enable bit is high when the fan may turn.

Top module: `fan_speed_selector`

## Requirements
- R1: During and directly after a synchronous active-low reset, `level_code` is 0 (level 1), `fan_en` is 0 and `fan_onehot` is all zeros.
- R2: A button pulse sampled at a clock edge raises `level_code` by one after that edge. Codes 0, 1, 2 and 3 stand for speed levels 1 to 4.
- R3: A button pulse sampled while `level_code` is 3 sets `level_code` to 0.
- R4: If `dev_active` is low at a clock edge, then after that edge `fan_en` is 0 and `fan_onehot` is all zeros.
- R5: If `dev_active` is high at a clock edge, then after that edge `fan_en` is 1 and `fan_onehot` has exactly bit `level_code` set. The remembered level is kept through parking, so the speed used before parking comes back.
- R6: Button pulses received while parked still advance `level_code`, but the fan stays off until a request returns.
- R7: If no button pulse is sampled at an edge, `level_code` keeps its value.
- R8: `fan_onehot` never has more than one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| btn_pulse | input | 1 | Single-cycle speed button pulse, already debounced |
| dev_active | input | 1 | High while the device requests airflow |
| level_code | output | 2 | Remembered speed level, binary (0 = level 1) |
| fan_onehot | output | 4 | One-hot running level; all zeros while parked |
| fan_en | output | 1 | Fan may run |

## Verification
Every result is due exactly one clock edge after the input that causes it. A pulse sampled at edge N shows on `level_code` after edge N, and the same holds for the park or run decision taken from `dev_active` at edge N. The bench drives inputs on the falling edge and advances its reference model at the same rising edge as the design. It compares all three outputs one nanosecond after that rising edge, so no result is checked early or late. Random bursts of requests and presses are mixed with directed runs: a full wrap of the level ring, presses while parked followed by a resume, and a reset in the middle of operation.

// File: rtl/fan_sel_pkg.sv
// Package: shared types for the fan speed selector.
// Assumes nothing beyond being compiled before the modules that import it.
package fan_sel_pkg;

    // Run/park decision carried between the park controller and the decoder.
    typedef enum logic {
        FAN_PARK = 1'b0,
        FAN_RUN  = 1'b1
    } fan_mode_e;

endpackage

// File: rtl/fan_level_ring.sv
// Module: fan_level_ring
// Holds the remembered speed level and advances it by one on each step
// pulse, wrapping from the last level to the first. The park state is not
// seen here, so the level survives any number of parked cycles.
// Assumes step_i is a single-cycle pulse synchronous to clk.
module fan_level_ring #(
    parameter int N_LEVELS = 4,
    localparam int LVL_W = (N_LEVELS > 1) ? $clog2(N_LEVELS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    output logic [LVL_W-1:0] level_o
);

    localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(N_LEVELS - 1);

    logic [LVL_W-1:0] lvl_q;

    // Level register: reset to the first level, advance and wrap on step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= '0;
        end else if (step_i) begin
            if (lvl_q == LAST_LVL) begin
                lvl_q <= '0;
            end else begin
                lvl_q <= lvl_q + 1'b1;
            end
        end
    end

    assign level_o = lvl_q;

    // R3: a step from the last level lands on the first.
    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && level_o == LAST_LVL) |=> (level_o == '0));

    // R2: a step below the last level adds exactly one.
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && level_o != LAST_LVL) |=> (level_o == $past(level_o) + 1'b1));

    // R7: without a step the level holds.
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(level_o));

endmodule

// File: rtl/fan_park_ctrl.sv
// Module: fan_park_ctrl
// Two-state controller that sends the fan to park whenever the device
// request is idle and back to run when it returns. Reset leaves it parked.
// Assumes req_i is synchronous to clk.
module fan_park_ctrl
    import fan_sel_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req_i,
    output fan_mode_e mode_o
);

    fan_mode_e mode_q;
    fan_mode_e mode_d;

    // Next mode: run while a request is present, otherwise park.
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            FAN_PARK: if (req_i)  mode_d = FAN_RUN;
            FAN_RUN:  if (!req_i) mode_d = FAN_PARK;
            default:  mode_d = FAN_PARK;
        endcase
    end

    // Mode register: reset to park so the fan stays off until asked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= FAN_PARK;
        end else begin
            mode_q <= mode_d;
        end
    end

    assign mode_o = mode_q;

endmodule

// File: rtl/fan_level_decode.sv
// Module: fan_level_decode
// Turns the remembered level and the run/park mode into the one-hot drive
// vector and the fan enable. Purely combinational.
// Assumes level_i is below N_LEVELS.
module fan_level_decode
    import fan_sel_pkg::*;
#(
    parameter int N_LEVELS = 4,
    localparam int LVL_W = (N_LEVELS > 1) ? $clog2(N_LEVELS) : 1
) (
    input  logic [LVL_W-1:0]    level_i,
    input  fan_mode_e           mode_i,
    output logic [N_LEVELS-1:0] onehot_o,
    output logic                en_o
);

    // One bit per level: set only for the selected level while running.
    for (genvar g = 0; g < N_LEVELS; g++) begin : g_bit
        assign onehot_o[g] = (mode_i == FAN_RUN) && (level_i == LVL_W'(g));
    end

    // Enable follows the run mode.
    assign en_o = (mode_i == FAN_RUN);

    // R8: never more than one drive bit.
    always_comb begin
        p_onehot_r8: assert ($onehot0(onehot_o));
    end

endmodule

// File: rtl/fan_speed_selector.sv
// Module: fan_speed_selector (top)
// Single-button fan speed selector with automatic park. The level ring
// keeps the chosen speed; the park controller follows the device request;
// the decoder builds the outputs. All results appear one edge after input.
// Assumes btn_pulse is debounced, single-cycle and synchronous to clk.
module fan_speed_selector
    import fan_sel_pkg::*;
#(
    parameter int N_LEVELS = 4,
    localparam int LVL_W = (N_LEVELS > 1) ? $clog2(N_LEVELS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                btn_pulse,
    input  logic                dev_active,
    output logic [LVL_W-1:0]    level_code,
    output logic [N_LEVELS-1:0] fan_onehot,
    output logic                fan_en
);

    logic [LVL_W-1:0] level_w;
    fan_mode_e        mode_w;

    // Speed memory.
    fan_level_ring #(.N_LEVELS(N_LEVELS)) i_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (btn_pulse),
        .level_o (level_w)
    );

    // Run/park tracking.
    fan_park_ctrl i_park (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (dev_active),
        .mode_o (mode_w)
    );

    // Output decoding.
    fan_level_decode #(.N_LEVELS(N_LEVELS)) i_dec (
        .level_i  (level_w),
        .mode_i   (mode_w),
        .onehot_o (fan_onehot),
        .en_o     (fan_en)
    );

    assign level_code = level_w;

    // R1: the cycle after reset shows level 1 with the fan off.
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (level_code == '0 && !fan_en && fan_onehot == '0));

    // R4: an idle request parks the fan at the next edge.
    p_park_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_active |=> (!fan_en && fan_onehot == '0));

    // R5: a present request drives exactly the remembered level.
    p_resume_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dev_active |=> (fan_en && fan_onehot == (N_LEVELS'(1) << level_code)));

    // R6: presses while parked change the level but not the enable.
    p_parked_press_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (btn_pulse && !dev_active) |=> (!fan_en && level_code != $past(level_code)));

endmodule

// File: tb/test_fan_speed_selector.sv
// Bench for fan_speed_selector: directed corner cases plus seeded random
// stimulus, checked against a reference model kept in bench variables.
module test_fan_speed_selector;

    localparam int NL = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       btn_pulse = 1'b0;
    logic       dev_active = 1'b0;
    logic [1:0] level_code;
    logic [3:0] fan_onehot;
    logic       fan_en;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Reference state.
    int exp_lvl  = 0;
    bit exp_park = 1'b1;

    always #5 clk = ~clk;

    fan_speed_selector #(.N_LEVELS(NL)) i_fan_speed_selector (
        .clk        (clk),
        .rst_n      (rst_n),
        .btn_pulse  (btn_pulse),
        .dev_active (dev_active),
        .level_code (level_code),
        .fan_onehot (fan_onehot),
        .fan_en     (fan_en)
    );

    function automatic logic [3:0] exp_onehot(int lvl, bit park);
        return park ? 4'b0000 : (4'b0001 << lvl);
    endfunction

    function automatic int next_lvl(int lvl, bit press);
        return press ? ((lvl + 1) % NL) : lvl;
    endfunction

    task automatic check(string req);
        logic [3:0] eo;
        eo = exp_onehot(exp_lvl, exp_park);
        n_vec++;
        if (level_code !== 2'(exp_lvl) || fan_onehot !== eo || fan_en !== !exp_park) begin
            n_fail++;
            $display("FAIL %s: got code=%0d onehot=%b en=%b, expected code=%0d onehot=%b en=%b",
                     req, level_code, fan_onehot, fan_en, exp_lvl, eo, !exp_park);
        end
    endtask

    // One clock: drive at the falling edge, update the model, check after the rising edge.
    task automatic cycle(bit rst, bit press, bit act, string req);
        @(negedge clk);
        rst_n      = !rst;
        btn_pulse  = press;
        dev_active = act;
        @(posedge clk);
        if (rst) begin
            exp_lvl  = 0;
            exp_park = 1'b1;
        end else begin
            exp_lvl  = next_lvl(exp_lvl, press);
            exp_park = !act;
        end
        #1;
        check(req);
    endtask

    initial begin
        // R1: reset state.
        cycle(1, 0, 0, "R1");
        cycle(1, 1, 1, "R1");
        cycle(0, 0, 0, "R4");
        // R5: request starts the fan at level 1.
        cycle(0, 0, 1, "R5");
        // R2, R3: four presses walk the levels and wrap.
        for (int i = 0; i < 4; i++) cycle(0, 1, 1, (i == 3) ? "R3" : "R2");
        cycle(0, 0, 1, "R7");
        cycle(0, 1, 1, "R2");
        cycle(0, 1, 1, "R2");
        // R4: park at level 3.
        cycle(0, 0, 0, "R4");
        cycle(0, 0, 0, "R7");
        // R6: presses while parked move the level but keep the fan off.
        cycle(0, 1, 0, "R6");
        cycle(0, 1, 0, "R6");
        cycle(0, 0, 0, "R6");
        // R5: resume at the remembered level.
        cycle(0, 0, 1, "R5");
        // R1: reset mid-run.
        cycle(1, 0, 1, "R1");
        cycle(0, 0, 1, "R5");
        // Random mix with request bursts; R8 covered by every onehot compare.
        begin
            void'($urandom(32'd1234));
            for (int i = 0; i < 3000; i++) begin
                bit press;
                bit act;
                bit rst;
                string tag;
                if (($urandom % 12) == 0) dev_active = !dev_active;
                act   = dev_active;
                press = (($urandom % 4) == 0);
                rst   = (($urandom % 500) == 0);
                if (rst)               tag = "R1";
                else if (press && !act) tag = "R6";
                else if (press)        tag = (exp_lvl == NL - 1) ? "R3" : "R2";
                else if (!act)         tag = "R4";
                else                   tag = "R8";
                cycle(rst, press, act, tag);
            end
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule